// File: doc/BRIEF.md
# Parallel Flash Bus Mode Decoder

This block is the host-side bus front end of a byte-wide flash memory. Each cycle it looks at the active-low chip enable, output enable and write enable strobes, the address bus, and three qualifiers: a program-voltage-present flag, a high-voltage flag on address bit 9, and a supply-below-lockout flag. From these it picks one bus mode. It then either drives read data onto an 8-bit data bus under a tri-state enable or keeps that bus released.

Read data comes from a small internal array or from the two identifier codes. The identifier codes can be reached in two ways: through the high-voltage address flag, or through a command register that holds the identifier command. Write cycles capture the data bus into that command register. A write only lands while the program voltage is present and the supply is above lockout. The program and erase algorithms, the command set beyond identifier selection, and analog levels are left to other blocks.

Top module: `flash_bus_decoder`

## Requirements
- R1: With ce_n_i high, mode_o is STANDBY (0) and dq_oe_o is 0, whatever oe_n_i, we_n_i, addr_i and the qualifiers are.
- R2: With ce_n_i low, oe_n_i high and we_n_i high, mode_o is OUT_DIS (1) and dq_oe_o is 0.
- R3: With ce_n_i low, oe_n_i low and we_n_i high, and no identifier source selected, mode_o is READ (2), dq_oe_o is 1, and dq_o equals (addr_i*37+11) mod 256.
- R4: During a read with a9_hv_i high and every address bit above bit 0 low, mode_o is ID_READ (3) and dq_o is 0x89 when addr_i[0]=0 or 0xB4 when addr_i[0]=1. If any higher address bit is set, the read returns array data.
- R5: A write phase is ce_n_i low, we_n_i low and oe_n_i high, and mode_o is WRITE (4) during it. At the first rising clock edge where the phase has ended, the byte sampled at the phase's last edge goes into the command register (cmd_data_o). In the cycle after that edge, cmd_valid_o is high for exactly one cycle.
- R6: While vpp_ok_i is low, a write ends with no capture and no cmd_valid_o, and the command register is forced to the read command 0x00 at the next edge.
- R7: While lockout_i is high at the end of a write, the write is discarded: there is no capture and no strobe.
- R8: After reset the command register holds 0x00, cmd_valid_o is 0, and reads return array data.
- R9: While vpp_ok_i is high and the command register holds 0x90, every read is ID_READ and returns 0x89 or 0xB4 by addr_i[0]. Any other command value gives array reads.
- R10: With ce_n_i, oe_n_i and we_n_i all low, mode_o is NOP (5), dq_oe_o is 0, and no capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | AW (6) | Byte address |
| vpp_ok_i | input | 1 | Program voltage present |
| a9_hv_i | input | 1 | High voltage on address bit 9 |
| lockout_i | input | 1 | Supply below write lockout |
| dq_i | input | 8 | Data bus input (write data) |
| dq_o | output | 8 | Data bus output (read data) |
| dq_oe_o | output | 1 | Data bus tri-state enable |
| mode_o | output | 3 | Decoded bus mode |
| cmd_data_o | output | 8 | Command register contents |
| cmd_valid_o | output | 1 | One-cycle strobe after an accepted write |

## Verification
On every cycle, the assertions check the following:
- standby and the write/output contention case keep the bus released;
- the command strobe never lasts more than one cycle;
- an accepted command always had the program voltage present and no lockout at the capturing edge;
- losing the program voltage returns the command register to the read command.

Only the bench scenarios can show that the captured byte is the one from the last cycle of the write phase. The same holds for the identifier codes and the array contents at each address, and for how the command register changes the meaning of later reads.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_OUT_DIS = 3'd1,
    MODE_READ    = 3'd2,
    MODE_ID_READ = 3'd3,
    MODE_WRITE   = 3'd4,
    MODE_NOP     = 3'd5
  } bus_mode_e;

  localparam logic [7:0] CMD_READ = 8'h00;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CODE_MFR = 8'h89;
  localparam logic [7:0] CODE_DEV = 8'hB4;
endpackage

// File: rtl/flash_mode_dec.sv
module flash_mode_dec
  import flash_bus_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          a9_hv_i,
  input  logic          cmd_ident_i,
  output bus_mode_e     mode_o,
  output logic          wr_act_o,
  output logic          id_sel_o
);
  logic hv_id;

  // high-voltage identifier path requires all address bits above bit 0 low
  assign hv_id    = a9_hv_i && (addr_i[AW-1:1] == '0);
  assign id_sel_o = hv_id || cmd_ident_i;
  assign wr_act_o = !ce_n_i && !we_n_i && oe_n_i;

  always_comb begin
    if (ce_n_i)                 mode_o = MODE_STANDBY;
    else if (!we_n_i && !oe_n_i) mode_o = MODE_NOP;
    else if (!we_n_i)           mode_o = MODE_WRITE;
    else if (oe_n_i)            mode_o = MODE_OUT_DIS;
    else if (id_sel_o)          mode_o = MODE_ID_READ;
    else                        mode_o = MODE_READ;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 6,
  parameter int MUL = 37,
  parameter int ADD = 11
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign mem[i] = 8'((i * MUL + ADD) % 256);
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/flash_cmd_reg.sv
module flash_cmd_reg
  import flash_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_act_i,
  input  logic [7:0] dq_i,
  input  logic       vpp_ok_i,
  input  logic       lockout_i,
  output logic [7:0] cmd_o,
  output logic       cmd_valid_o,
  output logic       cmd_ident_o
);
  logic       act_q;
  logic [7:0] hold_q;
  logic       wr_end, accept;

  assign wr_end = act_q && !wr_act_i;
  assign accept = wr_end && vpp_ok_i && !lockout_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      hold_q      <= '0;
      cmd_o       <= CMD_READ;
      cmd_valid_o <= 1'b0;
    end else begin
      act_q       <= wr_act_i;
      cmd_valid_o <= accept;
      if (wr_act_i) hold_q <= dq_i;
      if (!vpp_ok_i)   cmd_o <= CMD_READ;
      else if (accept) cmd_o <= hold_q;
    end
  end

  assign cmd_ident_o = vpp_ok_i && (cmd_o == CMD_IDENT);

  a_r6_cmd_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_ok_i |=> (cmd_o == CMD_READ));
  a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/flash_bus_decoder.sv
module flash_bus_decoder
  import flash_bus_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          vpp_ok_i,
  input  logic          a9_hv_i,
  input  logic          lockout_i,
  input  logic [7:0]    dq_i,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  output logic [2:0]    mode_o,
  output logic [7:0]    cmd_data_o,
  output logic          cmd_valid_o
);
  bus_mode_e  mode;
  logic       wr_act, id_sel, cmd_ident;
  logic [7:0] arr_data, id_data;

  flash_mode_dec #(.AW(AW)) u_dec (
    .ce_n_i, .oe_n_i, .we_n_i, .addr_i, .a9_hv_i,
    .cmd_ident_i(cmd_ident),
    .mode_o(mode), .wr_act_o(wr_act), .id_sel_o(id_sel)
  );

  flash_array #(.AW(AW)) u_arr (.addr_i, .data_o(arr_data));

  flash_cmd_reg u_cmd (
    .clk_i, .rst_ni, .wr_act_i(wr_act), .dq_i, .vpp_ok_i, .lockout_i,
    .cmd_o(cmd_data_o), .cmd_valid_o, .cmd_ident_o(cmd_ident)
  );

  assign id_data = addr_i[0] ? CODE_DEV : CODE_MFR;
  assign dq_oe_o = (mode == MODE_READ) || (mode == MODE_ID_READ);
  assign dq_o    = !dq_oe_o ? 8'h00 : (id_sel ? id_data : arr_data);
  assign mode_o  = mode;

  a_r1_standby_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |-> !dq_oe_o);
  a_r10_nop_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && !we_n_i) |-> !dq_oe_o);
  a_r6_valid_needs_vpp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(vpp_ok_i));
  a_r7_valid_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !$past(lockout_i));
endmodule

// File: tb/flash_bus_decoder_tb.sv
module flash_bus_decoder_tb;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, vpp = 0, a9 = 0, lock = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = '0, dq_out, cmd_data;
  logic dq_oe, cmd_valid;
  logic [2:0] mode;

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R8";

  // reference model state
  int m_cmd = 0, m_hold = 0;
  bit m_act_q = 0, m_valid = 0;

  always #2 clk = ~clk;

  flash_bus_decoder #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .vpp_ok_i(vpp), .a9_hv_i(a9), .lockout_i(lock), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .mode_o(mode), .cmd_data_o(cmd_data),
    .cmd_valid_o(cmd_valid)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_hold = 0; m_act_q = 0; m_valid = 0;
    end else begin
      bit act, endw;
      act = !ce_n && !we_n && oe_n;
      endw = m_act_q && !act;
      m_valid = endw && vpp && !lock;
      if (!vpp) m_cmd = 0;
      else if (m_valid) m_cmd = m_hold;
      if (act) m_hold = dq_in;
      m_act_q = act;
    end
  end

  task automatic cmp(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check();
    int e_mode, e_oe, e_data;
    bit idsel;
    idsel = (a9 && (addr >> 1) == 0) || (vpp && m_cmd == 'h90);
    e_oe = 0; e_data = 0;
    if (ce_n) e_mode = 0;
    else if (!oe_n && !we_n) e_mode = 5;
    else if (!we_n) e_mode = 4;
    else if (oe_n) e_mode = 1;
    else begin
      e_mode = idsel ? 3 : 2;
      e_oe = 1;
      e_data = idsel ? (addr[0] ? 'hB4 : 'h89) : ((int'(addr) * 37 + 11) % 256);
    end
    cmp("mode", int'(mode), e_mode);
    cmp("dq_oe", int'(dq_oe), e_oe);
    cmp("dq", int'(dq_out), e_data);
    cmp("cmd_data", int'(cmd_data), m_cmd);
    cmp("cmd_valid", int'(cmd_valid), int'(m_valid));
  endtask

  task automatic cyc(bit c, bit o, bit w, int a, bit v, bit h, bit l, int d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = AW'(a); vpp = v; a9 = h; lock = l;
    dq_in = 8'(d);
    #1 check();
  endtask

  task automatic idle(bit v);
    cyc(1, 1, 1, 0, v, 0, 0, 0);
  endtask

  task automatic write_byte(int d, bit v, bit l);
    cyc(0, 1, 0, 3, v, 0, l, 'h5A);
    cyc(0, 1, 0, 3, v, 0, l, d);
    cyc(0, 1, 1, 3, v, 0, l, 0);
    idle(v);
    idle(v);
  endtask

  initial begin
    #1 check(); // R8 reset state
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle(0);
    // R8: default array reads after reset
    req = "R8";
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, i * 9, 1, 0, 0, 0);
    // R1: standby with all don't-care combinations
    req = "R1";
    for (int k = 0; k < 32; k++) cyc(1, k[0], k[1], k * 5, k[2], k[3], k[4], k);
    // R2: output disable with don't-care qualifiers
    req = "R2";
    for (int k = 0; k < 8; k++) cyc(0, 1, 1, k * 7, k[0], k[1], k[2], 0);
    // R3: array reads over the address range
    req = "R3";
    for (int i = 0; i < 64; i += 5) cyc(0, 0, 1, i, i % 2, 0, 0, 0);
    cyc(0, 0, 1, 63, 0, 0, 0, 0);
    // R4: high-voltage identifier path
    req = "R4";
    cyc(0, 0, 1, 0, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 1, 1, 0, 0);
    cyc(0, 0, 1, 2, 0, 1, 0, 0);
    cyc(0, 0, 1, 33, 0, 1, 0, 0);
    // R5 / R9: identifier command then reads
    req = "R5";
    write_byte('h90, 1, 0);
    req = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, i * 11, 1, 0, 0, 0);
    // R5: other command restores array reads
    req = "R5";
    write_byte('hFF, 1, 0);
    req = "R9";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, i + 20, 1, 0, 0, 0);
    // R7: lockout discards a write
    req = "R7";
    write_byte('h90, 1, 1);
    cyc(0, 0, 1, 4, 1, 0, 0, 0);
    // R6: write without program voltage is ignored
    req = "R6";
    write_byte('h90, 0, 0);
    cyc(0, 0, 1, 5, 0, 0, 0, 0);
    // R6: dropping program voltage clears the identifier command
    req = "R6";
    write_byte('h90, 1, 0);
    cyc(0, 0, 1, 6, 1, 0, 0, 0);
    idle(0);
    idle(1);
    cyc(0, 0, 1, 6, 1, 0, 0, 0);
    // R5: write ended by chip enable rising first
    req = "R5";
    cyc(0, 1, 0, 0, 1, 0, 0, 'h90);
    cyc(1, 1, 0, 0, 1, 0, 0, 0);
    idle(1);
    cyc(0, 0, 1, 9, 1, 0, 0, 0);
    // R10: write and output enable together is NOP, no capture
    req = "R10";
    write_byte('h00, 1, 0);
    cyc(0, 0, 0, 2, 1, 0, 0, 'h90);
    cyc(0, 0, 0, 2, 1, 0, 0, 'h90);
    cyc(0, 1, 1, 2, 1, 0, 0, 0);
    idle(1);
    cyc(0, 0, 1, 2, 1, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule